// File: doc/BRIEF.md
# Wide Data Path and Parity Unit for a Parallel Bus Initiator

This block sits beside the transaction controller of a bus initiator on a shared, clocked parallel bus with 32-bit halves. It adds the optional upper 32-bit half of the bus to a transaction and generates and checks even parity on both halves. When the controller starts a transaction it may ask for the wide data path. The unit then raises the width request during the address phase and drives the upper address bits and a copy of the command on the upper half. It watches the device-select response for the target's width acknowledge. If the acknowledge is missing, it releases the upper half and the transfer carries on at 32 bits.

Addresses with a non-zero upper word go out as two address cycles. The first cycle carries the low word with the dual-address command code. The second carries the high word with the real command. Zero upper words take one cycle. Parity for each half goes out one clock after the values it covers. The unit checks what it observes on the bus, and it reports address-phase and special-cycle errors on the system-error line and read data errors on a separate data-error line.

Top module: `wide_bus_ext`

## Requirements
- R1: While reset is held, all output enables are low, the width request (active low) is high, width64 is 0, and both error outputs (active low) are high.
- R2: When the upper 32 address bits are zero, the address phase is one cycle: low half = address bits 31:0 with the command on C/BE[3:0]. If the wide path was requested, the upper half carries address bits 63:32 (zero) with a duplicate of the command on C/BE[7:4], and the width request is low.
- R3: When the upper address bits are non-zero, the address phase is two cycles. The first has the low address word with command code 4'b1101 on C/BE[3:0]. The second has the high address word with the real command on C/BE[3:0]. If the wide path was requested, the upper half carries the high address word and the real command in both cycles.
- R4: A target that pulls device select and width acknowledge low in the same cycle makes width64 high from the next cycle. The upper AD half then carries the upper write data and C/BE[7:4] the upper byte enables.
- R5: Device select low with the width acknowledge high makes the unit release the upper AD and C/BE halves from the next cycle on, and width64 stays 0.
- R6: A width acknowledge seen while device select is high has no effect on width64 or on the upper-half drive.
- R7: Each half's parity output equals the XOR of that half's AD and C/BE outputs in the previous cycle, and it is enabled only in cycles following one in which that half's AD was driven.
- R8: A parity mismatch on either half observed during any address cycle pulls the system-error output low for one cycle, two cycles after that address cycle.
- R9: A parity mismatch on a read data beat (command bit 0 = 0) pulls the data-error output low two cycles after the beat. The upper half is checked only when width64 is set.
- R10: For a special cycle (command 4'b0001), a data-beat parity mismatch is reported on the system-error output, never on the data-error output.
- R11: A start request during a transaction is ignored. An end request returns the unit to idle, with every enable released and the width request high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Controller starts a transaction (taken only when idle) |
| txn_end | input | 1 | Controller ends the current transaction |
| txn_addr | input | 64 | Full transaction address |
| txn_cmd | input | 4 | Bus command code; bit 0 set means write |
| txn_want_wide | input | 1 | Request the 64-bit data path |
| dat_valid | input | 1 | Write data on dat_wr is valid this cycle |
| dat_beat | input | 1 | A data transfer completes this cycle |
| dat_wr | input | 64 | Write data for both halves |
| dat_be | input | 8 | Active-low byte enables for both halves |
| bus_ad_o | output | 64 | AD value driven on the bus |
| bus_ad_oe | output | 2 | AD drive enable per half (bit 1 = upper) |
| bus_cbe_o | output | 8 | Command / byte-enable value driven on the bus |
| bus_cbe_oe | output | 2 | C/BE drive enable per half |
| bus_par_o | output | 2 | Parity driven per half |
| bus_par_oe | output | 2 | Parity drive enable per half |
| bus_wreq_n | output | 1 | Width request, active low |
| bus_ad_i | input | 64 | AD value observed on the bus |
| bus_cbe_i | input | 8 | C/BE value observed on the bus |
| bus_par_i | input | 2 | Parity observed per half |
| bus_sel_n | input | 1 | Target device select, active low |
| bus_wack_n | input | 1 | Target width acknowledge, active low |
| width64 | output | 1 | Wide data path negotiated for this transaction |
| sys_err_n | output | 1 | System error report, active low |
| data_err_n | output | 1 | Data parity error report, active low |

## Verification
The assertions assume that the controller raises dat_beat only in the data phase or in the cycle in which device select arrives, and that txn_end is a single pulse. They also assume that the observed C/BE lines follow what the unit drives. The bench meets these assumptions by looping C/BE and the initiator's own AD and parity straight back onto the observed inputs. It creates parity faults only by flipping observed AD bits or by presenting a wrong parity bit from its target model in the cycle after a beat. It presents device select and width acknowledge only in the waiting and data states, and never mid-address unless it is testing that they are ignored.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_WAIT,
    ST_DATA
  } wbx_state_e;

  localparam logic [3:0] CMD_DUAL    = 4'b1101;
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;

  function automatic logic cmd_is_write(input logic [3:0] c);
    return c[0];
  endfunction

  function automatic logic cmd_is_special(input logic [3:0] c);
    return c == CMD_SPECIAL;
  endfunction

endpackage

// File: rtl/wbx_seq.sv
module wbx_seq
  import wbx_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  txn_start,
  input  logic                  txn_end,
  input  logic [2*HALF_W-1:0]   txn_addr,
  input  logic [CBE_W-1:0]      txn_cmd,
  input  logic                  txn_want_wide,
  input  logic                  sel_n,
  input  logic                  wack_n,
  output wbx_state_e            state,
  output logic [2*HALF_W-1:0]   addr_q,
  output logic [CBE_W-1:0]      cmd_q,
  output logic                  want_q,
  output logic                  dual_q,
  output logic                  wide_q,
  output logic                  decide,
  output logic                  wide_now
);
  localparam int BUS_W = 2 * HALF_W;

  wbx_state_e nxt;

  // width decision happens only when the target selects during the wait state
  assign decide   = (state == ST_WAIT) && !sel_n;
  assign wide_now = decide ? (want_q && !wack_n) : wide_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (txn_start) nxt = ST_ADR1;
      ST_ADR1: nxt = dual_q ? ST_ADR2 : ST_WAIT;
      ST_ADR2: nxt = ST_WAIT;
      ST_WAIT: if (decide) nxt = ST_DATA;
      ST_DATA: nxt = ST_DATA;
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE && txn_end) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      cmd_q  <= '0;
      want_q <= 1'b0;
      dual_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && txn_start) begin
        addr_q <= txn_addr;
        cmd_q  <= txn_cmd;
        want_q <= txn_want_wide;
        dual_q <= |txn_addr[BUS_W-1:HALF_W];
      end
      if (nxt == ST_IDLE)
        wide_q <= 1'b0;
      else if (decide)
        wide_q <= want_q && !wack_n;
    end
  end

endmodule

// File: rtl/wbx_drive.sv
module wbx_drive
  import wbx_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int CBE_W  = 4
) (
  input  wbx_state_e            state,
  input  logic [2*HALF_W-1:0]   addr_q,
  input  logic [CBE_W-1:0]      cmd_q,
  input  logic                  want_q,
  input  logic                  dual_q,
  input  logic                  wide_q,
  input  logic                  dat_valid,
  input  logic [2*HALF_W-1:0]   dat_wr,
  input  logic [2*CBE_W-1:0]    dat_be,
  output logic [2*HALF_W-1:0]   ad_o,
  output logic [1:0]            ad_oe,
  output logic [2*CBE_W-1:0]    cbe_o,
  output logic [1:0]            cbe_oe,
  output logic                  wreq_n
);
  localparam int BUS_W = 2 * HALF_W;
  localparam int CBE_BUS = 2 * CBE_W;

  logic upper_on;
  logic is_wr;

  assign is_wr    = cmd_is_write(cmd_q);
  // before the decision the upper half stays driven if it was requested
  assign upper_on = (state == ST_WAIT) ? want_q : wide_q;
  assign wreq_n   = !(want_q && state != ST_IDLE);

  always_comb begin
    ad_o   = '0;
    cbe_o  = '0;
    ad_oe  = '0;
    cbe_oe = '0;
    unique case (state)
      ST_ADR1: begin
        ad_o[HALF_W-1:0]  = addr_q[HALF_W-1:0];
        cbe_o[CBE_W-1:0]  = dual_q ? CMD_DUAL : cmd_q;
        ad_oe[0]          = 1'b1;
        cbe_oe[0]         = 1'b1;
        if (want_q) begin
          ad_o[BUS_W-1:HALF_W]   = addr_q[BUS_W-1:HALF_W];
          cbe_o[CBE_BUS-1:CBE_W] = cmd_q;
          ad_oe[1]               = 1'b1;
          cbe_oe[1]              = 1'b1;
        end
      end
      ST_ADR2: begin
        ad_o[HALF_W-1:0]  = addr_q[BUS_W-1:HALF_W];
        cbe_o[CBE_W-1:0]  = cmd_q;
        ad_oe[0]          = 1'b1;
        cbe_oe[0]         = 1'b1;
        if (want_q) begin
          ad_o[BUS_W-1:HALF_W]   = addr_q[BUS_W-1:HALF_W];
          cbe_o[CBE_BUS-1:CBE_W] = cmd_q;
          ad_oe[1]               = 1'b1;
          cbe_oe[1]              = 1'b1;
        end
      end
      ST_WAIT, ST_DATA: begin
        cbe_o[CBE_W-1:0] = dat_be[CBE_W-1:0];
        cbe_oe[0]        = 1'b1;
        if (is_wr) begin
          ad_o[HALF_W-1:0] = dat_wr[HALF_W-1:0];
          ad_oe[0]         = dat_valid;
        end
        if (upper_on) begin
          cbe_o[CBE_BUS-1:CBE_W] = dat_be[CBE_BUS-1:CBE_W];
          cbe_oe[1]              = 1'b1;
          if (is_wr) begin
            ad_o[BUS_W-1:HALF_W] = dat_wr[BUS_W-1:HALF_W];
            ad_oe[1]             = dat_valid;
          end
        end
      end
      default: begin
        ad_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/wbx_lane.sv
module wbx_lane #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] drv_ad,
  input  logic [CW-1:0] drv_cbe,
  input  logic          drv_oe,
  input  logic [DW-1:0] obs_ad,
  input  logic [CW-1:0] obs_cbe,
  input  logic          obs_par,
  input  logic          chk_en,
  input  logic          chk_sys,
  output logic          par_o,
  output logic          par_oe,
  output logic          err_sys,
  output logic          err_dat
);

  // even parity: the returned bit makes the total count of ones even
  function automatic logic even_fill(input logic [DW-1:0] a, input logic [CW-1:0] c);
    return ^{a, c};
  endfunction

  logic cap_v;
  logic cap_par;
  logic cap_sys;
  logic mismatch;

  assign mismatch = cap_v && (obs_par != cap_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_o   <= 1'b0;
      par_oe  <= 1'b0;
      cap_v   <= 1'b0;
      cap_par <= 1'b0;
      cap_sys <= 1'b0;
      err_sys <= 1'b0;
      err_dat <= 1'b0;
    end else begin
      par_o   <= even_fill(drv_ad, drv_cbe);
      par_oe  <= drv_oe;
      cap_v   <= chk_en;
      cap_par <= even_fill(obs_ad, obs_cbe);
      cap_sys <= chk_sys;
      err_sys <= mismatch && cap_sys;
      err_dat <= mismatch && !cap_sys;
    end
  end

endmodule

// File: rtl/wide_bus_ext.sv
module wide_bus_ext
  import wbx_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  txn_start,
  input  logic                  txn_end,
  input  logic [2*HALF_W-1:0]   txn_addr,
  input  logic [CBE_W-1:0]      txn_cmd,
  input  logic                  txn_want_wide,
  input  logic                  dat_valid,
  input  logic                  dat_beat,
  input  logic [2*HALF_W-1:0]   dat_wr,
  input  logic [2*CBE_W-1:0]    dat_be,
  output logic [2*HALF_W-1:0]   bus_ad_o,
  output logic [1:0]            bus_ad_oe,
  output logic [2*CBE_W-1:0]    bus_cbe_o,
  output logic [1:0]            bus_cbe_oe,
  output logic [1:0]            bus_par_o,
  output logic [1:0]            bus_par_oe,
  output logic                  bus_wreq_n,
  input  logic [2*HALF_W-1:0]   bus_ad_i,
  input  logic [2*CBE_W-1:0]    bus_cbe_i,
  input  logic [1:0]            bus_par_i,
  input  logic                  bus_sel_n,
  input  logic                  bus_wack_n,
  output logic                  width64,
  output logic                  sys_err_n,
  output logic                  data_err_n
);
  localparam int N_HALF = 2;

  wbx_state_e            state;
  logic [2*HALF_W-1:0]   addr_q;
  logic [CBE_W-1:0]      cmd_q;
  logic                  want_q;
  logic                  dual_q;
  logic                  wide_q;
  logic                  decide;
  logic                  wide_now;

  // named internal events, visible to the bound checker
  logic                  addr_cyc;
  logic                  in_wait;
  logic                  in_idle;
  logic                  dual2;
  logic                  beat_ok;
  logic                  chk_rd;
  logic                  chk_sys;
  logic                  sys_evt;
  logic                  dat_evt;
  logic [N_HALF-1:0]     chk_en;
  logic [N_HALF-1:0]     err_sys;
  logic [N_HALF-1:0]     err_dat;

  wbx_seq #(.HALF_W(HALF_W), .CBE_W(CBE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_start     (txn_start),
    .txn_end       (txn_end),
    .txn_addr      (txn_addr),
    .txn_cmd       (txn_cmd),
    .txn_want_wide (txn_want_wide),
    .sel_n         (bus_sel_n),
    .wack_n        (bus_wack_n),
    .state         (state),
    .addr_q        (addr_q),
    .cmd_q         (cmd_q),
    .want_q        (want_q),
    .dual_q        (dual_q),
    .wide_q        (wide_q),
    .decide        (decide),
    .wide_now      (wide_now)
  );

  wbx_drive #(.HALF_W(HALF_W), .CBE_W(CBE_W)) u_drive (
    .state     (state),
    .addr_q    (addr_q),
    .cmd_q     (cmd_q),
    .want_q    (want_q),
    .dual_q    (dual_q),
    .wide_q    (wide_q),
    .dat_valid (dat_valid),
    .dat_wr    (dat_wr),
    .dat_be    (dat_be),
    .ad_o      (bus_ad_o),
    .ad_oe     (bus_ad_oe),
    .cbe_o     (bus_cbe_o),
    .cbe_oe    (bus_cbe_oe),
    .wreq_n    (bus_wreq_n)
  );

  assign addr_cyc = (state == ST_ADR1) || (state == ST_ADR2);
  assign in_wait  = (state == ST_WAIT);
  assign in_idle  = (state == ST_IDLE);
  assign dual2    = (state == ST_ADR2);
  assign beat_ok  = dat_beat && ((state == ST_DATA) || decide);
  assign chk_rd   = beat_ok && (!cmd_is_write(cmd_q) || cmd_is_special(cmd_q));
  assign chk_sys  = addr_cyc || cmd_is_special(cmd_q);
  assign sys_evt  = (|chk_en) && chk_sys;
  assign dat_evt  = (|chk_en) && !chk_sys;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    if (h == 0) begin : g_low
      assign chk_en[h] = addr_cyc || chk_rd;
    end else begin : g_up
      assign chk_en[h] = (addr_cyc && want_q) || (chk_rd && wide_now);
    end

    wbx_lane #(.DW(HALF_W), .CW(CBE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_ad  (bus_ad_o[h*HALF_W +: HALF_W]),
      .drv_cbe (bus_cbe_o[h*CBE_W +: CBE_W]),
      .drv_oe  (bus_ad_oe[h]),
      .obs_ad  (bus_ad_i[h*HALF_W +: HALF_W]),
      .obs_cbe (bus_cbe_i[h*CBE_W +: CBE_W]),
      .obs_par (bus_par_i[h]),
      .chk_en  (chk_en[h]),
      .chk_sys (chk_sys),
      .par_o   (bus_par_o[h]),
      .par_oe  (bus_par_oe[h]),
      .err_sys (err_sys[h]),
      .err_dat (err_dat[h])
    );
  end

  assign width64    = wide_q;
  assign sys_err_n  = ~|err_sys;
  assign data_err_n = ~|err_dat;

endmodule

// File: rtl/wbx_checker.sv
module wbx_checker
  import wbx_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int CBE_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                txn_end,
  input logic [2*HALF_W-1:0] bus_ad_o,
  input logic [1:0]          bus_ad_oe,
  input logic [2*CBE_W-1:0]  bus_cbe_o,
  input logic [1:0]          bus_cbe_oe,
  input logic [1:0]          bus_par_o,
  input logic [1:0]          bus_par_oe,
  input logic                bus_wreq_n,
  input logic                bus_sel_n,
  input logic                bus_wack_n,
  input logic                width64,
  input logic                sys_err_n,
  input logic                data_err_n,
  input logic                addr_cyc,
  input logic                in_wait,
  input logic                in_idle,
  input logic                dual2,
  input logic                sys_evt,
  input logic                dat_evt
);

  p_upper_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && bus_ad_oe[1]) |-> !bus_wreq_n);

  p_dual_code_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dual2 |-> ($past(bus_cbe_o[CBE_W-1:0]) == CMD_DUAL));

  p_accept_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !bus_sel_n && !bus_wack_n && !txn_end) |=> width64);

  p_fallback_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !bus_sel_n && bus_wack_n) |=> (!bus_ad_oe[1] && !bus_cbe_oe[1] && !width64));

  p_par_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_par_oe[0] |-> (bus_par_o[0] == ^$past({bus_ad_o[HALF_W-1:0], bus_cbe_o[CBE_W-1:0]})));

  p_par_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_par_oe[1] |-> (bus_par_o[1] == ^$past({bus_ad_o[2*HALF_W-1:HALF_W], bus_cbe_o[2*CBE_W-1:CBE_W]})));

  p_sys_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_err_n |-> $past(sys_evt, 2));

  p_dat_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_err_n |-> $past(dat_evt, 2));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (bus_ad_oe == 2'b00 && bus_cbe_oe == 2'b00 && bus_wreq_n));

endmodule

bind wide_bus_ext wbx_checker #(.HALF_W(HALF_W), .CBE_W(CBE_W)) u_wbx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txn_end    (txn_end),
  .bus_ad_o   (bus_ad_o),
  .bus_ad_oe  (bus_ad_oe),
  .bus_cbe_o  (bus_cbe_o),
  .bus_cbe_oe (bus_cbe_oe),
  .bus_par_o  (bus_par_o),
  .bus_par_oe (bus_par_oe),
  .bus_wreq_n (bus_wreq_n),
  .bus_sel_n  (bus_sel_n),
  .bus_wack_n (bus_wack_n),
  .width64    (width64),
  .sys_err_n  (sys_err_n),
  .data_err_n (data_err_n),
  .addr_cyc   (addr_cyc),
  .in_wait    (in_wait),
  .in_idle    (in_idle),
  .dual2      (dual2),
  .sys_evt    (sys_evt),
  .dat_evt    (dat_evt)
);

// File: tb/wide_bus_ext_test.sv
module wide_bus_ext_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_start, txn_end, txn_want_wide;
  logic [63:0] txn_addr;
  logic [3:0]  txn_cmd;
  logic        dat_valid, dat_beat;
  logic [63:0] dat_wr;
  logic [7:0]  dat_be;
  logic [63:0] bus_ad_o, bus_ad_i;
  logic [1:0]  bus_ad_oe, bus_cbe_oe, bus_par_o, bus_par_oe, bus_par_i;
  logic [7:0]  bus_cbe_o, bus_cbe_i;
  logic        bus_wreq_n, bus_sel_n, bus_wack_n;
  logic        width64, sys_err_n, data_err_n;

  // bench-side target model and fault injection
  logic        tgt_drv;
  logic [63:0] tgt_ad;
  logic [1:0]  tgt_par;
  logic [63:0] ad_flip;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign bus_ad_i     = (tgt_drv ? tgt_ad : bus_ad_o) ^ ad_flip;
  assign bus_cbe_i    = bus_cbe_o;
  assign bus_par_i[0] = bus_par_oe[0] ? bus_par_o[0] : tgt_par[0];
  assign bus_par_i[1] = bus_par_oe[1] ? bus_par_o[1] : tgt_par[1];

  wide_bus_ext uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
    .txn_addr(txn_addr), .txn_cmd(txn_cmd), .txn_want_wide(txn_want_wide),
    .dat_valid(dat_valid), .dat_beat(dat_beat), .dat_wr(dat_wr), .dat_be(dat_be),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_cbe_o(bus_cbe_o),
    .bus_cbe_oe(bus_cbe_oe), .bus_par_o(bus_par_o), .bus_par_oe(bus_par_oe),
    .bus_wreq_n(bus_wreq_n), .bus_ad_i(bus_ad_i), .bus_cbe_i(bus_cbe_i),
    .bus_par_i(bus_par_i), .bus_sel_n(bus_sel_n), .bus_wack_n(bus_wack_n),
    .width64(width64), .sys_err_n(sys_err_n), .data_err_n(data_err_n)
  );

  // counts ones, even-parity bit makes the total even
  function automatic logic ref_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return ones[0];
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    txn_start = 0; txn_end = 0; txn_want_wide = 0; txn_addr = '0; txn_cmd = '0;
    dat_valid = 0; dat_beat = 0; dat_wr = '0; dat_be = '0;
    bus_sel_n = 1; bus_wack_n = 1; tgt_drv = 0; tgt_ad = '0; tgt_par = '0; ad_flip = '0;
  endtask

  task automatic finish_txn();
    txn_end = 1;
    step();
    txn_end = 0;
    idle_inputs();
    step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    repeat (3) step();
    chk("R1", "ad_oe", bus_ad_oe, 2'b00);
    chk("R1", "cbe_oe", bus_cbe_oe, 2'b00);
    chk("R1", "par_oe", bus_par_oe, 2'b00);
    chk("R1", "wreq_n", bus_wreq_n, 1'b1);
    chk("R1", "width64", width64, 1'b0);
    chk("R1", "sys_err_n", sys_err_n, 1'b1);
    chk("R1", "data_err_n", data_err_n, 1'b1);
    rst_n = 1;
    step();
  endtask

  task automatic t_single_wide_write();
    txn_addr = 64'h0000_0000_1234_5678; txn_cmd = 4'h7; txn_want_wide = 1; txn_start = 1;
    step();
    chk("R2", "ad lo", bus_ad_o[31:0], 32'h1234_5678);
    chk("R2", "ad hi", bus_ad_o[63:32], 32'h0);
    chk("R2", "cbe", bus_cbe_o, 8'h77);
    chk("R2", "ad_oe", bus_ad_oe, 2'b11);
    chk("R2", "wreq_n", bus_wreq_n, 1'b0);
    txn_start = 0; dat_valid = 1; dat_wr = 64'hCAFE_0001_BEEF_0002; dat_be = 8'h30;
    bus_sel_n = 0; bus_wack_n = 0;
    step();
    chk("R7", "par lo", bus_par_o[0], ref_par(32'h1234_5678, 4'h7));
    chk("R7", "par hi", bus_par_o[1], ref_par(32'h0, 4'h7));
    chk("R7", "par_oe", bus_par_oe, 2'b11);
    step();
    chk("R4", "width64", width64, 1'b1);
    chk("R4", "ad hi", bus_ad_o[63:32], 32'hCAFE_0001);
    chk("R4", "cbe", bus_cbe_o, 8'h30);
    chk("R4", "ad_oe", bus_ad_oe, 2'b11);
    chk("R7", "par hi data", bus_par_o[1], ref_par(32'hCAFE_0001, 4'h3));
    txn_end = 1;
    step();
    chk("R11", "ad_oe after end", bus_ad_oe, 2'b00);
    chk("R11", "cbe_oe after end", bus_cbe_oe, 2'b00);
    chk("R11", "wreq_n after end", bus_wreq_n, 1'b1);
    chk("R11", "width64 after end", width64, 1'b0);
    txn_end = 0;
    idle_inputs();
    step();
  endtask

  task automatic t_dual_read_fallback();
    txn_addr = 64'h0000_00AB_0000_1000; txn_cmd = 4'h6; txn_want_wide = 1; txn_start = 1;
    step();
    chk("R3", "first ad lo", bus_ad_o[31:0], 32'h0000_1000);
    chk("R3", "first cbe lo", bus_cbe_o[3:0], 4'hD);
    chk("R3", "first ad hi", bus_ad_o[63:32], 32'h0000_00AB);
    chk("R3", "first cbe hi", bus_cbe_o[7:4], 4'h6);
    txn_start = 0;
    step();
    chk("R3", "second ad lo", bus_ad_o[31:0], 32'h0000_00AB);
    chk("R3", "second cbe lo", bus_cbe_o[3:0], 4'h6);
    chk("R3", "second cbe hi", bus_cbe_o[7:4], 4'h6);
    dat_be = 8'h00; bus_sel_n = 1; bus_wack_n = 0;
    step();
    chk("R3", "read wait ad_oe", bus_ad_oe, 2'b00);
    step();
    chk("R6", "width64 ack w/o sel", width64, 1'b0);
    chk("R6", "cbe_oe ack w/o sel", bus_cbe_oe, 2'b11);
    bus_sel_n = 0; bus_wack_n = 1;
    step();
    chk("R5", "width64 fallback", width64, 1'b0);
    chk("R5", "cbe_oe fallback", bus_cbe_oe, 2'b01);
    chk("R5", "ad_oe fallback", bus_ad_oe, 2'b00);
    // narrow read beat with a bad upper parity: must be ignored
    tgt_drv = 1; tgt_ad = 64'h5555_0000_0F0F_1234; dat_beat = 1;
    step();
    dat_beat = 0;
    tgt_par[0] = ref_par(32'h0F0F_1234, 4'h0);
    tgt_par[1] = ~ref_par(32'h5555_0000, 4'h0);
    step();
    chk("R9", "narrow upper ignored", data_err_n, 1'b1);
    chk("R9", "narrow no sys", sys_err_n, 1'b1);
    tgt_ad = 64'h0000_0000_0000_0007; dat_beat = 1;
    step();
    dat_beat = 0;
    tgt_par[0] = ~ref_par(32'h7, 4'h0);
    step();
    chk("R9", "low data err", data_err_n, 1'b0);
    chk("R9", "low data err not sys", sys_err_n, 1'b1);
    step();
    chk("R9", "data err one cycle", data_err_n, 1'b1);
    finish_txn();
  endtask

  task automatic t_wide_read_err();
    txn_addr = 64'h0000_0000_0000_2000; txn_cmd = 4'h6; txn_want_wide = 1; txn_start = 1;
    step();
    txn_start = 0; bus_sel_n = 0; bus_wack_n = 0; dat_be = 8'h00;
    step();
    step();
    chk("R4", "width64 read", width64, 1'b1);
    tgt_drv = 1; tgt_ad = 64'h0000_0003_1111_0000; dat_beat = 1;
    step();
    dat_beat = 0;
    tgt_par[0] = ref_par(32'h1111_0000, 4'h0);
    tgt_par[1] = ~ref_par(32'h0000_0003, 4'h0);
    step();
    chk("R9", "upper data err wide", data_err_n, 1'b0);
    finish_txn();
  endtask

  task automatic t_addr_err();
    txn_addr = 64'h0000_0000_0000_4000; txn_cmd = 4'h7; txn_want_wide = 1; txn_start = 1;
    step();
    txn_start = 0; ad_flip = 64'h0000_0001_0000_0000;
    step();
    ad_flip = '0;
    chk("R8", "sys not yet", sys_err_n, 1'b1);
    step();
    chk("R8", "sys err addr", sys_err_n, 1'b0);
    chk("R8", "no data err", data_err_n, 1'b1);
    step();
    chk("R8", "sys err one cycle", sys_err_n, 1'b1);
    finish_txn();
  endtask

  task automatic t_special();
    txn_addr = 64'h0000_0000_0000_6000; txn_cmd = 4'h1; txn_want_wide = 0; txn_start = 1;
    step();
    txn_start = 0; bus_sel_n = 0; bus_wack_n = 1;
    step();
    step();
    dat_valid = 1; dat_wr = 64'h77; dat_be = 8'h00; dat_beat = 1; ad_flip = 64'h1;
    step();
    dat_beat = 0; ad_flip = '0;
    step();
    chk("R10", "special sys err", sys_err_n, 1'b0);
    chk("R10", "special no data err", data_err_n, 1'b1);
    finish_txn();
  endtask

  task automatic t_busy_start();
    txn_addr = 64'h0000_0000_0000_8000; txn_cmd = 4'h7; txn_want_wide = 0; txn_start = 1;
    step();
    txn_start = 0; dat_be = 8'hF5;
    step();
    txn_start = 1; txn_addr = 64'h0000_0000_FFFF_0000; txn_cmd = 4'h6; txn_want_wide = 1;
    step();
    chk("R11", "busy start cbe", bus_cbe_o[3:0], 4'h5);
    chk("R11", "busy start wreq_n", bus_wreq_n, 1'b1);
    chk("R11", "busy start ad_oe", bus_ad_oe, 2'b00);
    txn_start = 0; txn_end = 1;
    step();
    txn_end = 0;
    step();
    chk("R11", "idle after end ad_oe", bus_ad_oe, 2'b00);
    chk("R11", "idle after end cbe_oe", bus_cbe_oe, 2'b00);
    idle_inputs();
    step();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    report();
  end

  initial begin
    t_reset();
    t_single_wide_write();
    t_dual_read_fallback();
    t_wide_read_err();
    t_addr_err();
    t_special();
    t_busy_start();
    report();
  end

endmodule